// File: doc/BRIEF.md
# Lockable Register Map Write Controller

This block is the byte-addressed register file that sits behind a serial slave port. Each clock it takes one write strobe with an 8-bit address and data byte. It decides whether that write may land, and it returns read data for a separate read address with no cycle of delay. The bus front end and the nonvolatile memory are separate blocks. This block only holds the live contents and applies the write rules.

Shadow storage covers 0x20–0x47 and is split into three regions: 0x20–0x2F, 0x30–0x3F and 0x40–0x47. Each region has its own lock input. A write is dropped silently when any of these holds: its region is locked, the address is not writable, or the address is above 0x4F. A feature register at 0x08 holds two bits. One latches a low level seen on an external pin. The other gates writes to the slave address at 0x32.

The slave address goes out on a port and takes effect on the cycle after it is written. A single-cycle copy pulse saves the live slave address as the stored value. A warm reset (`rst_ni`) returns the live address to that stored value. A power-on reset (`por_ni`) returns the stored value to the default.

Top module: `lock_regmap`

## Requirements
- R1: After reset, address 0x08 reads 0x80, `slave_addr_o` equals the stored address, and every shadow byte reads 0x00.
- R2: With its region lock at 0, a write to any address in 0x20–0x47 other than 0x32 stores the byte. It reads back on the cycle after the write.
- R3: Lock bit k (bit 0 for 0x20–0x2F, bit 1 for 0x30–0x3F, bit 2 for 0x40–0x47) set to 1 discards writes to that region, including 0x32 under bit 1.
- R4: Writes to 0x00–0x07, 0x09–0x1F and 0x48–0xFF are ignored, including 0xFE. Reads of those addresses return 0x00.
- R5: At 0x08, bit 1 is the address-write enable. A write sets it to data bit 1. Bits 6:2 and bit 0 always read 0.
- R6: Bit 7 of 0x08 becomes 0 on the cycle after `pin_ni` is sampled low. Only a write with data bit 7 = 1, while the pin is high, returns it to 1. A write of 0 to bit 7 has no effect.
- R7: A write to 0x32 changes the slave address only when the enable bit is 1. The address is taken from data bits 7:1; bit 0 is dropped and reads 0. The new value appears on `slave_addr_o` on the next cycle.
- R8: A `copy_i` pulse saves the current slave address as the stored value. Asserting `rst_ni` makes `slave_addr_o` return to the stored value.
- R9: Asserting `por_ni` sets the stored and live slave address to 7'h34.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous warm reset, active low |
| por_ni | input | 1 | Asynchronous power-on reset, active low; also resets the stored address |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 8 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| lock_i | input | 3 | Region lock flags, 1 = locked |
| pin_ni | input | 1 | External pin sampled by the latch bit, active low |
| copy_i | input | 1 | Save live slave address as stored value |
| slave_addr_o | output | 7 | Live 7-bit slave address |

## Verification
The bench probes the region edges 0x2F, 0x47 and 0x48, the ceiling, and 0xFE. An off-by-one region decode would either drop a valid byte or keep a stray one. The slave address is written with the enable off, then with it on and the region locked. A weak gate would move the bus address when it should not. Further checks cover:
- the pin held low during a write of 1 to the latch bit, which catches a reversed priority;
- a warm reset before a copy, which must restore the old address;
- a warm reset after a copy, which must restore the saved address. A copy that does nothing, or a reset that goes to the constant default, fails one of these two.

// File: rtl/lock_regmap_pkg.sv
package lock_regmap_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 8;
  localparam int N_BLK   = 3;
  localparam int SADDR_W = 7;

  localparam logic [ADDR_W-1:0] FEAT_ADDR  = 8'h08;
  localparam logic [ADDR_W-1:0] SADDR_ADDR = 8'h32;
  localparam logic [ADDR_W-1:0] WR_CEIL    = 8'h4F;
  localparam logic [ADDR_W-1:0] SHD_LO     = 8'h20;
  localparam logic [ADDR_W-1:0] SHD_HI     = 8'h47;
  localparam int SHD_DEPTH = int'(SHD_HI) - int'(SHD_LO) + 1;

  localparam logic [N_BLK-1:0][ADDR_W-1:0] BLK_LO = {8'h40, 8'h30, 8'h20};
  localparam logic [N_BLK-1:0][ADDR_W-1:0] BLK_HI = {8'h47, 8'h3F, 8'h2F};

  localparam int FEAT_PIN_BIT = 7;
  localparam int FEAT_AWE_BIT = 1;

  localparam logic [SADDR_W-1:0] SADDR_DFLT = 7'h34;

  typedef struct packed {
    logic shadow;
    logic feat;
    logic saddr;
  } wr_sel_t;
endpackage

// File: rtl/rm_wr_filter.sv
module rm_wr_filter
  import lock_regmap_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_BLK-1:0]  lock_i,
  input  logic              addr_we_i,
  output wr_sel_t           sel_o
);
  logic [N_BLK-1:0] blk_hit;
  logic locked, in_shd, below_ceil;

  for (genvar k = 0; k < N_BLK; k++) begin : g_blk
    assign blk_hit[k] = (addr_i >= BLK_LO[k]) && (addr_i <= BLK_HI[k]);
  end

  assign locked     = |(blk_hit & lock_i);
  assign in_shd     = (addr_i >= SHD_LO) && (addr_i <= SHD_HI);
  assign below_ceil = (addr_i <= WR_CEIL);

  always_comb begin
    sel_o.shadow = wr_en_i && below_ceil && in_shd && !locked && (addr_i != SADDR_ADDR);
    sel_o.saddr  = wr_en_i && below_ceil && (addr_i == SADDR_ADDR) && !locked && addr_we_i;
    sel_o.feat   = wr_en_i && below_ceil && (addr_i == FEAT_ADDR);
  end
endmodule

// File: rtl/rm_feature_reg.sv
module rm_feature_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic wr_i,
  input  logic pin_set_i,
  input  logic awe_i,
  output logic pin_latch_o,
  output logic addr_we_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_latch_o <= 1'b1;
      addr_we_o   <= 1'b0;
    end else begin
      // a low pin beats a concurrent set request
      if (!pin_ni)                pin_latch_o <= 1'b0;
      else if (wr_i && pin_set_i) pin_latch_o <= 1'b1;
      if (wr_i) addr_we_o <= awe_i;
    end
  end
endmodule

// File: rtl/rm_slave_addr.sv
module rm_slave_addr
  import lock_regmap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               wr_i,
  input  logic [SADDR_W-1:0] data_i,
  input  logic               copy_i,
  output logic [SADDR_W-1:0] addr_o
);
  logic [SADDR_W-1:0] stored_q, live_q;
  logic               live_vld_q;

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)     stored_q <= SADDR_DFLT;
    else if (copy_i) stored_q <= addr_o;
  end

  // warm reset drops the override; output falls back to the stored copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q     <= '0;
      live_vld_q <= 1'b0;
    end else if (wr_i) begin
      live_q     <= data_i;
      live_vld_q <= 1'b1;
    end
  end

  assign addr_o = live_vld_q ? live_q : stored_q;
endmodule

// File: rtl/rm_shadow_ram.sv
module rm_shadow_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 40,
  parameter logic [ADDR_W-1:0] BASE = 8'h20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (we_i && waddr_i == BASE + ADDR_W'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == BASE + ADDR_W'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/lock_regmap.sv
module lock_regmap
  import lock_regmap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic [N_BLK-1:0]   lock_i,
  input  logic               pin_ni,
  input  logic               copy_i,
  output logic [SADDR_W-1:0] slave_addr_o
);
  logic    rst_n_all;
  wr_sel_t sel;
  logic    pin_latch_q, addr_we_q;
  logic [DATA_W-1:0] shd_rdata;

  assign rst_n_all = rst_ni & por_ni;

  rm_wr_filter u_filter (
    .wr_en_i   (wr_en_i),
    .addr_i    (wr_addr_i),
    .lock_i    (lock_i),
    .addr_we_i (addr_we_q),
    .sel_o     (sel)
  );

  rm_feature_reg u_feat (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_all),
    .pin_ni      (pin_ni),
    .wr_i        (sel.feat),
    .pin_set_i   (wr_data_i[FEAT_PIN_BIT]),
    .awe_i       (wr_data_i[FEAT_AWE_BIT]),
    .pin_latch_o (pin_latch_q),
    .addr_we_o   (addr_we_q)
  );

  rm_slave_addr u_saddr (
    .clk_i  (clk_i),
    .rst_ni (rst_n_all),
    .por_ni (por_ni),
    .wr_i   (sel.saddr),
    .data_i (wr_data_i[DATA_W-1:1]),
    .copy_i (copy_i),
    .addr_o (slave_addr_o)
  );

  rm_shadow_ram #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (SHD_DEPTH),
    .BASE   (SHD_LO)
  ) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_all),
    .we_i    (sel.shadow),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (shd_rdata)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == FEAT_ADDR) begin
      rd_data_o[FEAT_PIN_BIT] = pin_latch_q;
      rd_data_o[FEAT_AWE_BIT] = addr_we_q;
    end else if (rd_addr_i == SADDR_ADDR) begin
      rd_data_o = {slave_addr_o, 1'b0};
    end else begin
      rd_data_o = shd_rdata;
    end
  end
endmodule

// File: rtl/lock_regmap_chk.sv
module lock_regmap_chk
  import lock_regmap_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               por_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  wr_addr_i,
  input logic [DATA_W-1:0]  wr_data_i,
  input logic [ADDR_W-1:0]  rd_addr_i,
  input logic [DATA_W-1:0]  rd_data_o,
  input logic [N_BLK-1:0]   lock_i,
  input logic               pin_ni,
  input logic [SADDR_W-1:0] slave_addr_o,
  input logic               pin_latch_q,
  input logic               addr_we_q
);
  for (genvar k = 0; k < N_BLK; k++) begin : g_lock
    AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
      (wr_en_i && lock_i[k] && wr_addr_i >= BLK_LO[k] && wr_addr_i <= BLK_HI[k]
       && rd_addr_i == wr_addr_i)
      |=> (!$stable(rd_addr_i) || $stable(rd_data_o))); // R3
  end

  AST_CEIL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && wr_addr_i > WR_CEIL) |=> ($stable(slave_addr_o) && $stable(addr_we_q))); // R4

  AST_FEAT_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (rd_addr_i == FEAT_ADDR) |-> ((rd_data_o & 8'h7D) == 8'h00)); // R5

  AST_PIN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !pin_ni |=> !pin_latch_q); // R6

  AST_PIN_SET_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(pin_latch_q) |-> $past(wr_en_i && wr_addr_i == FEAT_ADDR && wr_data_i[7] && pin_ni)); // R6

  AST_SADDR_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !(wr_en_i && wr_addr_i == SADDR_ADDR) |=> $stable(slave_addr_o)); // R7

  AST_SADDR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && wr_addr_i == SADDR_ADDR && !addr_we_q) |=> $stable(slave_addr_o)); // R7

  AST_SADDR_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (rd_addr_i == SADDR_ADDR) |-> !rd_data_o[0]); // R7
endmodule

bind lock_regmap lock_regmap_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_ni       (por_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .lock_i       (lock_i),
  .pin_ni       (pin_ni),
  .slave_addr_o (slave_addr_o),
  .pin_latch_q  (pin_latch_q),
  .addr_we_q    (addr_we_q)
);

// File: tb/lock_regmap_test.sv
module lock_regmap_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, por_ni = 1'b0;
  logic       wr_en = 1'b0, pin_n = 1'b1, copy = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [2:0] lock = '0;
  logic [7:0] rd_data;
  logic [6:0] saddr;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  lock_regmap uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .lock_i(lock), .pin_ni(pin_n), .copy_i(copy),
    .slave_addr_o(saddr)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] wa;
    logic [7:0] wd;
    logic [7:0] ra;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 8'h20, 8'hA5, 8'h20, 8'hA5, 4'd2},  // R2 low edge
    '{1'b1, 8'h47, 8'h3C, 8'h47, 8'h3C, 4'd2},  // R2 top edge
    '{1'b1, 8'h2F, 8'h11, 8'h2F, 8'h11, 4'd2},  // R2 region boundary
    '{1'b1, 8'h48, 8'hFF, 8'h48, 8'h00, 4'd4},  // R4 just past shadow
    '{1'b1, 8'h10, 8'h55, 8'h10, 8'h00, 4'd4},  // R4 low hole
    '{1'b1, 8'hFE, 8'h77, 8'hFE, 8'h00, 4'd4},  // R4 command address
    '{1'b1, 8'h08, 8'hFF, 8'h08, 8'h82, 4'd5},  // R5 reserved bits dropped
    '{1'b1, 8'h08, 8'h7D, 8'h08, 8'h80, 4'd6},  // R6 zero to bit 7 no effect
    '{1'b1, 8'h32, 8'h50, 8'h32, 8'h68, 4'd7},  // R7 enable off
    '{1'b1, 8'h08, 8'h02, 8'h08, 8'h82, 4'd5},  // R5 enable on
    '{1'b1, 8'h32, 8'h51, 8'h32, 8'h50, 4'd7},  // R7 enabled write, lsb dropped
    '{1'b0, 8'h20, 8'h00, 8'h20, 8'hA5, 4'd2}   // R2 contents held
  };

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string tag, logic [7:0] a, logic [7:0] exp);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    por_ni = 1'b1; rst_ni = 1'b1;
    @(negedge clk);
    // R1 / R9 reset state
    rd_check("R1 feature reset", 8'h08, 8'h80);
    rd_check("R1 shadow reset", 8'h20, 8'h00);
    check("R9 default address", {1'b0, saddr}, 8'h34);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      wr_en = VEC[i].we; wr_addr = VEC[i].wa; wr_data = VEC[i].wd; rd_addr = VEC[i].ra;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), rd_data, VEC[i].exp);
    end
    check("R7 port follows write", {1'b0, saddr}, 8'h28);

    // R3 region locks
    lock = 3'b010;
    wr(8'h30, 8'h99); rd_check("R3 region1 locked", 8'h30, 8'h00);
    wr(8'h32, 8'h66); check("R3 address locked", {1'b0, saddr}, 8'h28);
    lock = 3'b001;
    wr(8'h20, 8'h00); rd_check("R3 region0 locked", 8'h20, 8'hA5);
    lock = 3'b100;
    wr(8'h40, 8'hEE); rd_check("R3 region2 locked", 8'h40, 8'h00);
    lock = 3'b000;
    wr(8'h30, 8'h99); rd_check("R2 after unlock", 8'h30, 8'h99);

    // R6 pin latch
    @(negedge clk); pin_n = 1'b0;
    @(negedge clk); #1;
    rd_check("R6 pin low clears", 8'h08, 8'h02);
    wr(8'h08, 8'h82);
    rd_check("R6 pin low wins", 8'h08, 8'h02);
    pin_n = 1'b1;
    wr(8'h08, 8'h80);
    rd_check("R6 set by write", 8'h08, 8'h80);

    // R8 warm reset before copy restores old stored value
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1; #1;
    check("R8 reset restores stored", {1'b0, saddr}, 8'h34);
    rd_check("R1 feature after reset", 8'h08, 8'h80);
    rd_check("R1 shadow after reset", 8'h30, 8'h00);

    wr(8'h08, 8'h02);
    wr(8'h32, 8'h5A);
    @(negedge clk); copy = 1'b1;
    @(negedge clk); copy = 1'b0;
    wr(8'h32, 8'h20);
    check("R7 second write", {1'b0, saddr}, 8'h10);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1; #1;
    check("R8 reset restores copied", {1'b0, saddr}, 8'h2D);

    // R9 power-on reset returns to default
    @(negedge clk); por_ni = 1'b0;
    @(negedge clk); por_ni = 1'b1; #1;
    check("R9 power-on default", {1'b0, saddr}, 8'h34);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule